// File: doc/BRIEF.md
# Crystal Trim Calibration Engine

This engine finds a setting for the 10-bit capacitor bank that trims a nominal 32 MHz crystal oscillator. A gated counter counts oscillator pulses over a fixed number of reference ticks. The default gate is one second of reference time, so the count is the frequency in hertz. The engine compares that count with a programmable target and tolerance and moves the trim code until the count falls inside the window. Switching in more capacitance lowers the oscillator frequency. A fast count therefore moves the search toward more capacitance, and a slow count moves it toward less.

The trim code mixes two weightings. The six low bits switch binary-weighted capacitors of 1, 2, 4, 8, 16 and 32 units. Each of the four high bits switches an equal capacitor of 64 units. The unit is 40 fF, so the full code gives 12.76 pF. The search therefore runs over effective capacitance steps, from 0 to 319. Each step it chooses is turned back into a code before it is applied. After every code change the engine lets the oscillator settle for a programmable number of reference ticks, then runs a gate. A single-cycle `start` launches a run. A single-cycle `done` ends it. The engine then holds the final code and a pass flag until the next run.

Top module: `xtal_trim_cal`

## Requirements
- R1: After reset the outputs are: `busy`, `done` and `pass` low, and `trim_code` equal to 0x19F.
- R2: A trim code is worth its bits [5:0] plus 64 times the number of ones in bits [9:6], a step count from 0 to 319. When the engine turns a step back into a code, bits [5:0] take the step modulo 64. The upper bits are filled from bit 6 upward, one bit for each whole 64 in the step.
- R3: The first trial of every run applies code 0x19F exactly as written, which is step 159. The value 159 is also the midpoint of the initial interval 0..319.
- R4: After each code change the engine waits `settle_ticks` reference ticks. It then counts `osc_pulse` over exactly GATE_TICKS reference ticks. `trim_code` does not change from the code change until that count is complete.
- R5: A count above target+tolerance moves the lower bound to trial+1. A count below target−tolerance moves the upper bound to trial−1. The next trial is the floor of the midpoint of the new bounds.
- R6: A count within target±tolerance ends the run. `done` pulses for one cycle with `pass` high and `busy` low, and `trim_code` holds the passing code.
- R7: The run ends with `pass` low when the interval empties, or when a fast count occurs at step 319 or a slow count at step 0. In that case `trim_code` holds the last trial code.
- R8: A run makes at most MAX_ITER measurements. If the tolerance has not been reached by then, it ends with `pass` low.
- R9: `start` while `busy` is high has no effect on the run, its trials or its result.
- R10: Pulses are counted in every cycle of the gate, including its first and last cycles, so a tolerance of zero can pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Single-cycle request to begin a calibration run |
| ref_tick | input | 1 | Reference time base strobe, one per reference period |
| osc_pulse | input | 1 | Synchronised oscillator edge strobe |
| target_count | input | CNT_W | Wanted count per gate |
| tolerance | input | CNT_W | Allowed deviation from the target, inclusive |
| settle_ticks | input | SET_W | Reference ticks to wait after a code change |
| busy | output | 1 | A run is in progress |
| done | output | 1 | Single-cycle end-of-run strobe |
| pass | output | 1 | The last run reached tolerance |
| trim_code | output | 10 | Capacitor bank code driven to the oscillator |

## Verification
Two events can fall in the same cycle: a new `start` request, and a measurement completing that moves the search to its next trial. The bench holds `start` high for a window of more than two full measurements in the middle of a run, so the request is still present when a measurement completes. It then checks that the run ends with the same code, pass flag and trial count as an undisturbed run. The other coincidence is an oscillator pulse on the first or last gate cycle. The bench sets the tolerance to zero, and the run passes only if those edge pulses are counted.

// File: rtl/xtal_trim_pkg.sv
package xtal_trim_pkg;

    localparam int CODE_W     = 10;
    localparam int FINE_W     = 6;
    localparam int COARSE_N   = CODE_W - FINE_W;
    localparam int COARSE_LSB = 1 << FINE_W;
    localparam int STEP_MAX   = (COARSE_LSB - 1) + COARSE_N * COARSE_LSB;
    localparam int STEP_W     = $clog2(STEP_MAX + 1);

    typedef logic [CODE_W-1:0] code_t;
    typedef logic [STEP_W-1:0] step_t;

    // Effective capacitance in units: binary part plus equal-weight part.
    function automatic step_t code_to_step(input code_t c);
        step_t s;
        s = step_t'(c[FINE_W-1:0]);
        for (int i = 0; i < COARSE_N; i++) begin
            if (c[FINE_W+i]) s = s + step_t'(COARSE_LSB);
        end
        return s;
    endfunction

endpackage

// File: rtl/xtal_trim_code_map.sv
module xtal_trim_code_map
    import xtal_trim_pkg::*;
(
    input  step_t step,
    output code_t code
);

    localparam int CRS_W = STEP_W - FINE_W;

    logic [CRS_W-1:0] coarse;

    assign coarse           = step[STEP_W-1:FINE_W];
    assign code[FINE_W-1:0] = step[FINE_W-1:0];

    // Equal-weight capacitors are switched in thermometer order from bit FINE_W.
    for (genvar g = 0; g < COARSE_N; g++) begin : g_therm
        assign code[FINE_W+g] = (coarse > CRS_W'(g));
    end

endmodule

// File: rtl/xtal_trim_gate_counter.sv
module xtal_trim_gate_counter #(
    parameter int GATE_TICKS = 10_000_000,
    parameter int CNT_W      = 26,
    parameter int SET_W      = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             meas_req,
    input  logic             ref_tick,
    input  logic             osc_pulse,
    input  logic [SET_W-1:0] settle_ticks,
    output logic             meas_active,
    output logic             meas_done,
    output logic [CNT_W-1:0] meas_count
);

    localparam int GW = $clog2(GATE_TICKS);
    localparam int TW = (SET_W > GW) ? SET_W : GW;

    typedef enum logic [1:0] {C_IDLE, C_SETTLE, C_GATE} cst_e;

    typedef struct packed {
        cst_e             st;
        logic [TW-1:0]    tick;
        logic [CNT_W-1:0] cnt;
        logic             done;
    } cnt_t;

    cnt_t q, d;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        case (q.st)
            C_IDLE: begin
                if (meas_req) begin
                    d.cnt  = '0;
                    d.tick = '0;
                    d.st   = (settle_ticks == '0) ? C_GATE : C_SETTLE;
                end
            end
            C_SETTLE: begin
                if (ref_tick) begin
                    if ((q.tick + TW'(1)) == TW'(settle_ticks)) begin
                        d.st   = C_GATE;
                        d.tick = '0;
                    end else begin
                        d.tick = q.tick + TW'(1);
                    end
                end
            end
            C_GATE: begin
                if (osc_pulse) d.cnt = q.cnt + CNT_W'(1);
                if (ref_tick) begin
                    if (q.tick == TW'(GATE_TICKS - 1)) begin
                        d.st   = C_IDLE;
                        d.done = 1'b1;
                    end else begin
                        d.tick = q.tick + TW'(1);
                    end
                end
            end
            default: d.st = C_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '{st: C_IDLE, tick: '0, cnt: '0, done: 1'b0};
        else        q <= d;
    end

    assign meas_active = (q.st != C_IDLE);
    assign meas_done   = q.done;
    assign meas_count  = q.cnt;

    AST_REQ_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        meas_req |-> (q.st == C_IDLE)); // R4
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == C_GATE && osc_pulse) |-> (q.cnt != '1)); // R4

endmodule

// File: rtl/xtal_trim_search.sv
module xtal_trim_search
    import xtal_trim_pkg::*;
#(
    parameter int    CNT_W      = 26,
    parameter int    MAX_ITER   = 10,
    parameter code_t START_CODE = 10'h19F
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             meas_done,
    input  logic [CNT_W-1:0] meas_count,
    input  logic [CNT_W-1:0] target,
    input  logic [CNT_W-1:0] tol,
    output logic             meas_req,
    output logic             busy,
    output logic             done,
    output logic             pass,
    output code_t            code
);

    localparam int    ITER_W     = $clog2(MAX_ITER + 1);
    localparam step_t START_STEP = code_to_step(START_CODE);
    localparam step_t TOP_STEP   = step_t'(STEP_MAX);

    typedef enum logic {S_IDLE, S_WAIT} sst_e;

    typedef struct packed {
        sst_e              st;
        step_t             lo;
        step_t             hi;
        step_t             trial;
        code_t             code;
        logic [ITER_W-1:0] iter;
        logic              req;
        logic              busy;
        logic              done;
        logic              pass;
    } srch_t;

    srch_t q, d;

    logic              too_fast, too_slow, edge_hit, empty;
    logic [CNT_W:0]    cnt_x, upper;
    logic [STEP_W:0]   span;
    logic [ITER_W-1:0] iter_n;
    step_t             nlo, nhi, mid;
    code_t             mid_code;

    always_comb begin
        cnt_x    = {1'b0, meas_count};
        upper    = {1'b0, target} + {1'b0, tol};
        too_fast = cnt_x > upper;
        too_slow = (cnt_x + {1'b0, tol}) < {1'b0, target};
        nlo      = too_fast ? q.trial + step_t'(1) : q.lo;
        nhi      = too_slow ? q.trial - step_t'(1) : q.hi;
        edge_hit = (too_fast && q.trial == TOP_STEP) || (too_slow && q.trial == '0);
        empty    = nlo > nhi;
        span     = {1'b0, nlo} + {1'b0, nhi};
        mid      = span[STEP_W:1];
        iter_n   = q.iter + ITER_W'(1);
    end

    xtal_trim_code_map u_map (
        .step (mid),
        .code (mid_code)
    );

    always_comb begin
        d      = q;
        d.req  = 1'b0;
        d.done = 1'b0;
        case (q.st)
            S_IDLE: begin
                if (start) begin
                    d.st    = S_WAIT;
                    d.lo    = '0;
                    d.hi    = TOP_STEP;
                    d.trial = START_STEP;
                    d.code  = START_CODE;
                    d.iter  = '0;
                    d.req   = 1'b1;
                    d.busy  = 1'b1;
                    d.pass  = 1'b0;
                end
            end
            S_WAIT: begin
                if (meas_done) begin
                    d.iter = iter_n;
                    if (!too_fast && !too_slow) begin
                        d.st   = S_IDLE;
                        d.busy = 1'b0;
                        d.done = 1'b1;
                        d.pass = 1'b1;
                    end else if (edge_hit || empty || int'(iter_n) >= MAX_ITER) begin
                        d.st   = S_IDLE;
                        d.busy = 1'b0;
                        d.done = 1'b1;
                    end else begin
                        d.lo    = nlo;
                        d.hi    = nhi;
                        d.trial = mid;
                        d.code  = mid_code;
                        d.req   = 1'b1;
                    end
                end
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{st: S_IDLE, lo: '0, hi: TOP_STEP, trial: START_STEP, code: START_CODE,
                   iter: '0, req: 1'b0, busy: 1'b0, done: 1'b0, pass: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign meas_req = q.req;
    assign busy     = q.busy;
    assign done     = q.done;
    assign pass     = q.pass;
    assign code     = q.code;

    AST_FIRST_TRIAL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.busy) |-> (q.code == START_CODE)); // R3
    AST_CODE_MATCHES_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        q.busy |-> (code_to_step(q.code) == q.trial)); // R2
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |=> !q.done); // R6
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |-> !q.busy); // R6
    AST_ITER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        int'(q.iter) <= MAX_ITER); // R8
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy && start && !meas_done) |=> !q.req); // R9

endmodule

// File: rtl/xtal_trim_cal.sv
module xtal_trim_cal
    import xtal_trim_pkg::*;
#(
    parameter int    GATE_TICKS = 10_000_000,
    parameter int    CNT_W      = 26,
    parameter int    SET_W      = 16,
    parameter int    MAX_ITER   = 10,
    parameter code_t START_CODE = 10'h19F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              ref_tick,
    input  logic              osc_pulse,
    input  logic [CNT_W-1:0]  target_count,
    input  logic [CNT_W-1:0]  tolerance,
    input  logic [SET_W-1:0]  settle_ticks,
    output logic              busy,
    output logic              done,
    output logic              pass,
    output logic [CODE_W-1:0] trim_code
);

    logic             meas_req, meas_active, meas_done;
    logic [CNT_W-1:0] meas_count;

    xtal_trim_gate_counter #(
        .GATE_TICKS (GATE_TICKS),
        .CNT_W      (CNT_W),
        .SET_W      (SET_W)
    ) u_counter (
        .clk          (clk),
        .rst_n        (rst_n),
        .meas_req     (meas_req),
        .ref_tick     (ref_tick),
        .osc_pulse    (osc_pulse),
        .settle_ticks (settle_ticks),
        .meas_active  (meas_active),
        .meas_done    (meas_done),
        .meas_count   (meas_count)
    );

    xtal_trim_search #(
        .CNT_W      (CNT_W),
        .MAX_ITER   (MAX_ITER),
        .START_CODE (START_CODE)
    ) u_search (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .meas_done  (meas_done),
        .meas_count (meas_count),
        .target     (target_count),
        .tol        (tolerance),
        .meas_req   (meas_req),
        .busy       (busy),
        .done       (done),
        .pass       (pass),
        .code       (trim_code)
    );

    AST_CODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        meas_active |=> $stable(trim_code)); // R4

endmodule

// File: tb/xtal_trim_cal_tb.sv
`timescale 1ns/1ps

// Oscillator stand-in: count per gate = 1000 - 2*step, blanked after each code change.
module xtal_osc_model #(
    parameter int ACC_W = 14,
    parameter int BLANK = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [9:0] code,
    output logic       pulse
);
    logic [ACC_W-1:0] acc;
    logic [9:0]       prev;
    int               blank;
    int               steps;
    int               rate;

    always @(posedge clk) begin
        if (!rst_n) begin
            acc   <= '0;
            prev  <= code;
            blank <= 0;
            pulse <= 1'b0;
        end else begin
            steps = int'(code[5:0]) + 64 * $countones(code[9:6]);
            rate  = 16 * (1000 - 2 * steps);
            if (code != prev) begin
                prev  <= code;
                blank <= BLANK;
                pulse <= 1'b0;
            end else if (blank > 0) begin
                blank <= blank - 1;
                pulse <= 1'b0;
            end else begin
                {pulse, acc} <= {1'b0, acc} + (ACC_W + 1)'(rate);
            end
        end
    end
endmodule

module xtal_trim_cal_tb;
    localparam int GATE   = 1024;
    localparam int CW     = 16;
    localparam int SW     = 8;
    localparam int SETTLE = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          start_l = 1'b0;
    logic          ref_tick = 1'b1;
    logic [CW-1:0] target = '0;
    logic [CW-1:0] tol = '0;
    logic [SW-1:0] settle = SW'(SETTLE);

    logic       osc_p, osc_pl;
    logic       busy, done, pass, busy_l, done_l, pass_l;
    logic [9:0] trim_code, trim_code_l;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    xtal_trim_cal #(.GATE_TICKS(GATE), .CNT_W(CW), .SET_W(SW), .MAX_ITER(10)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .ref_tick(ref_tick), .osc_pulse(osc_p),
        .target_count(target), .tolerance(tol), .settle_ticks(settle),
        .busy(busy), .done(done), .pass(pass), .trim_code(trim_code));

    xtal_trim_cal #(.GATE_TICKS(GATE), .CNT_W(CW), .SET_W(SW), .MAX_ITER(2)) u_dut_lim (
        .clk(clk), .rst_n(rst_n), .start(start_l), .ref_tick(ref_tick), .osc_pulse(osc_pl),
        .target_count(target), .tolerance(tol), .settle_ticks(settle),
        .busy(busy_l), .done(done_l), .pass(pass_l), .trim_code(trim_code_l));

    xtal_osc_model u_osc   (.clk(clk), .rst_n(rst_n), .code(trim_code),   .pulse(osc_p));
    xtal_osc_model u_osc_l (.clk(clk), .rst_n(rst_n), .code(trim_code_l), .pulse(osc_pl));

    // Trial monitors, sampled away from the active edge
    logic       busy_prev = 1'b0, busy_l_prev = 1'b0;
    int         trials = 0, trials_l = 0, last_cyc = 0, gap_min = 0;
    logic [9:0] first_code = '0, last_code = '0, last_code_l = '0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (busy && !busy_prev) begin
                trials     = 1;
                first_code = trim_code;
                last_code  = trim_code;
                last_cyc   = cyc;
                gap_min    = 1 << 30;
            end else if (busy && trim_code != last_code) begin
                trials    = trials + 1;
                if (cyc - last_cyc < gap_min) gap_min = cyc - last_cyc;
                last_code = trim_code;
                last_cyc  = cyc;
            end
            if (busy_l && !busy_l_prev) begin
                trials_l    = 1;
                last_code_l = trim_code_l;
            end else if (busy_l && trim_code_l != last_code_l) begin
                trials_l    = trials_l + 1;
                last_code_l = trim_code_l;
            end
        end
        busy_prev   = busy;
        busy_l_prev = busy_l;
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic wait_done(input bit lim, output bit ok);
        int n = 0;
        while (!(lim ? done_l : done) && n < 20000) begin
            @(negedge clk);
            n++;
        end
        ok = (n < 20000);
    endtask

    task automatic finish_check(input int exp_pass, input int exp_code, input int exp_trials, input string req);
        bit ok;
        wait_done(1'b0, ok);
        chk(ok, req, "run completes", int'(ok), 1);
        chk(pass == exp_pass[0], req, "pass flag", int'(pass), exp_pass);
        chk(trim_code == exp_code[9:0], req, "final code", int'(trim_code), exp_code);
        chk(trials == exp_trials, req, "trial count", trials, exp_trials);
        chk(first_code == 10'h19F, "R3", "first trial code", int'(first_code), 'h19F);
        chk(!busy, "R6", "busy low at done", int'(busy), 0);
        if (exp_trials > 1) chk(gap_min >= SETTLE + GATE, "R4", "cycles between code changes", gap_min, SETTLE + GATE);
        @(negedge clk);
        chk(!done, "R6", "done lasts one cycle", int'(done), 0);
        chk(trim_code == exp_code[9:0], "R6", "code held after done", int'(trim_code), exp_code);
    endtask

    task automatic kick(input int tgt, input int t);
        @(negedge clk);
        target = CW'(tgt);
        tol    = CW'(t);
        start  = 1'b1;
        @(negedge clk);
        start  = 1'b0;
    endtask

    task automatic t_reset;
        chk(!busy && !done && !pass, "R1", "status after reset", {busy, done, pass}, 0);
        chk(trim_code == 10'h19F, "R1", "code after reset", int'(trim_code), 'h19F);
        chk(trim_code_l == 10'h19F, "R1", "code after reset (limited)", int'(trim_code_l), 'h19F);
    endtask

    // R5 R2: converges to step 200 -> code 0x1C8 via 159,239,199,219,209,204,201,200
    task automatic t_converge;
        kick(600, 1);
        finish_check(1, 'h1C8, 8, "R5");
    endtask

    // R10: exact count 682 at step 159 passes with zero tolerance on first trial
    task automatic t_first_hit;
        kick(682, 0);
        finish_check(1, 'h19F, 1, "R10");
    endtask

    // R7: no step gives 601 exactly, interval empties after step 200
    task automatic t_empty;
        kick(601, 0);
        finish_check(0, 'h1C8, 8, "R7");
    endtask

    // R7: target above the fastest count walks down to step 0
    task automatic t_floor;
        kick(1100, 2);
        finish_check(0, 'h000, 8, "R7");
    endtask

    // R7 R2: target below the slowest count walks up to step 319, code 0x3FF
    task automatic t_ceiling;
        kick(300, 2);
        finish_check(0, 'h3FF, 9, "R7");
    endtask

    // R9: start held across measurement completions during a run
    task automatic t_restart_ignored;
        kick(600, 1);
        repeat (1500) @(negedge clk);
        start = 1'b1;
        repeat (2500) @(negedge clk);
        start = 1'b0;
        finish_check(1, 'h1C8, 8, "R9");
    endtask

    // R8: limit of two measurements, second trial step 239 -> code 0x1EF
    task automatic t_iter_limit;
        bit ok;
        @(negedge clk);
        target  = CW'(600);
        tol     = CW'(1);
        start_l = 1'b1;
        @(negedge clk);
        start_l = 1'b0;
        wait_done(1'b1, ok);
        chk(ok, "R8", "limited run completes", int'(ok), 1);
        chk(!pass_l, "R8", "pass flag at limit", int'(pass_l), 0);
        chk(trim_code_l == 10'h1EF, "R8", "code at limit", int'(trim_code_l), 'h1EF);
        chk(trials_l == 2, "R8", "measurements at limit", trials_l, 2);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_converge;
        t_first_hit;
        t_empty;
        t_floor;
        t_ceiling;
        t_restart_ignored;
        t_iter_limit;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog run did not finish actual=0x%0h expected=0x%0h", cyc, 190000);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule